// File: doc/BRIEF.md
# Dual-slope converter sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs without stopping and needs no start command. Each conversion has three working phases. In the autozero phase it stores the loop offset. In the integrate phase it applies the unknown input for a fixed time. In the read phase it discharges the integrator through a reference of opposite sign. The block drives one enable for each of the three analog switches and a select for the reference sign. It watches the comparator and the input polarity, and it latches the measured count for a display stage.

One chain of BCD decades does all the timing. The fixed phases end when this chain carries out of its top decade, which takes 10^DIGITS clocks. The variable read phase ends when the comparator reports that the integrator is back at its autozero level. The count reached at that point is the measurement. It is moved into the result latch on the same edge that leaves read, and one clock later a new autozero starts.

The state machine has six states. The working states are `PH_AZ`, `PH_INT` and `PH_READ`. The gap states are `PH_GAP_AI`, `PH_GAP_IR` and `PH_GAP_RA`. The transitions are:
- `PH_AZ`→`PH_GAP_AI` on counter carry.
- `PH_GAP_AI`→`PH_INT` unconditionally.
- `PH_INT`→`PH_GAP_IR` on counter carry, capturing the input polarity.
- `PH_GAP_IR`→`PH_READ` unconditionally.
- `PH_READ`→`PH_GAP_RA` on a comparator crossing (normal result) or on counter carry (overrange result). Both cases strobe the latch.
- `PH_GAP_RA`→`PH_AZ` unconditionally.

The counter is cleared in every gap state.

Top module: `dsadc_sequencer`

## Requirements
- R1: The switch enables run in the fixed order autozero, integrate, read, then autozero again, forever, with no external start.
- R2: `az_en` and `int_en` each stay high for exactly 10^DIGITS consecutive clocks per conversion. `cmp_zero` has no effect on these lengths.
- R3: Read ends in the first read clock in which `cmp_zero` is sampled high. The result is the number of read clocks before that one. It is given as BCD on `res_bcd`, with decade i (units at i=0) in bits [4i+3:4i].
- R4: At most one enable is high at any time. Exactly one clock with all enables low separates every pair of consecutive phases.
- R5: `pol_neg` is sampled on the last integrate clock. Throughout read, `ref_neg` is 1 when the sampled `pol_neg` was 0, and 0 when it was 1.
- R6: `res_bcd`, `res_neg` and `res_over` change only on the edge that ends read. `res_valid` is high for exactly that one following clock, which is the gap clock before autozero.
- R7: If 10^DIGITS read clocks pass with no crossing, read ends anyway. In that case `res_bcd` is all nines, `res_over` is 1, and the next autozero follows as usual. A crossing in the last read clock gives a normal result with `res_over` at 0.
- R8: `res_neg` equals the polarity captured at the end of the integrate phase of the same conversion.
- R9: While `rst` (synchronous, active high) is high, the block is in autozero with `az_en`=1, `int_en`=`ref_en`=`ref_neg`=0, the result latch at zero and `res_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_zero | input | 1 | Comparator: integrator back at autozero level |
| pol_neg | input | 1 | Sensed input polarity, 1 = negative |
| az_en | output | 1 | Autozero switch enable |
| int_en | output | 1 | Integrate (input) switch enable |
| ref_en | output | 1 | Reference switch enable |
| ref_neg | output | 1 | Reference sign select during read, 1 = negative reference |
| res_bcd | output | 4*DIGITS | Latched count, BCD |
| res_neg | output | 1 | Latched sign, 1 = negative input |
| res_over | output | 1 | Latched overrange flag |
| res_valid | output | 1 | One-clock pulse when the latch updates |

## Verification
The bench builds the block with DIGITS=2, so each fixed phase lasts 100 clocks and a full conversion takes about 300 clocks. With this setting the overrange path is cheap to reach. So is the boundary between a crossing in the last read clock (count 99) and no crossing at all, and a run can cover several conversions of both polarities. The comparator is held high outside read, which shows that it cannot shorten the fixed phases. The default of four decades changes only the counter length, not the control paths.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_AZ     = 3'd0,
        PH_GAP_AI = 3'd1,
        PH_INT    = 3'd2,
        PH_GAP_IR = 3'd3,
        PH_READ   = 3'd4,
        PH_GAP_RA = 3'd5
    } phase_t;

    localparam int BCD_W = 4;

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       inc,
    output logic [3:0] q,
    output logic       carry
);
    // One decade: counts 0..9, carries on the step from 9 back to 0.
    assign carry = inc && (q == 4'd9);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 4'd0;
        else if (inc)
            q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
    end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
    parameter int DIGITS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        en,
    output logic [4*DIGITS-1:0]         value,
    output logic                        ovf
);
    logic [DIGITS:0] inc_chain;

    assign inc_chain[0] = en;

    genvar i;
    generate
        for (i = 0; i < DIGITS; i++) begin : g_dec
            bcd_digit u_dig (
                .clk   (clk),
                .rst   (rst),
                .clr   (clr),
                .inc   (inc_chain[i]),
                .q     (value[4*i +: 4]),
                .carry (inc_chain[i+1])
            );
        end
    endgenerate

    // Carry out of the top decade: counter held all nines and is stepping.
    assign ovf = inc_chain[DIGITS];

    p_ovf_nines_r2: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (value == {DIGITS{4'h9}}));
endmodule

// File: rtl/dsadc_phase_fsm.sv
module dsadc_phase_fsm
    import dsadc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_ovf,
    input  logic cmp_zero,
    input  logic pol_neg,
    output logic cnt_clr,
    output logic cnt_en,
    output logic latch_stb,
    output logic latch_over,
    output logic sign_q,
    output logic az_en,
    output logic int_en,
    output logic ref_en,
    output logic ref_neg
);
    phase_t phase, phase_nx;
    logic   sign_nx;

    // Next-state and event decode.
    always_comb begin
        phase_nx   = phase;
        sign_nx    = sign_q;
        latch_stb  = 1'b0;
        latch_over = 1'b0;
        unique case (phase)
            PH_AZ: begin
                if (cnt_ovf) phase_nx = PH_GAP_AI;
            end
            PH_GAP_AI: phase_nx = PH_INT;
            PH_INT: begin
                if (cnt_ovf) begin
                    phase_nx = PH_GAP_IR;
                    sign_nx  = pol_neg;
                end
            end
            PH_GAP_IR: phase_nx = PH_READ;
            PH_READ: begin
                if (cmp_zero) begin
                    phase_nx  = PH_GAP_RA;
                    latch_stb = 1'b1;
                end else if (cnt_ovf) begin
                    phase_nx   = PH_GAP_RA;
                    latch_stb  = 1'b1;
                    latch_over = 1'b1;
                end
            end
            PH_GAP_RA: phase_nx = PH_AZ;
            default:   phase_nx = PH_AZ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_AZ;
            sign_q <= 1'b0;
        end else begin
            phase  <= phase_nx;
            sign_q <= sign_nx;
        end
    end

    // Output decode.
    always_comb begin
        az_en   = 1'b0;
        int_en  = 1'b0;
        ref_en  = 1'b0;
        ref_neg = 1'b0;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        unique case (phase)
            PH_AZ: begin
                az_en  = 1'b1;
                cnt_en = 1'b1;
            end
            PH_INT: begin
                int_en = 1'b1;
                cnt_en = 1'b1;
            end
            PH_READ: begin
                ref_en  = 1'b1;
                ref_neg = ~sign_q;
                cnt_en  = ~cmp_zero;
            end
            PH_GAP_AI, PH_GAP_IR, PH_GAP_RA: cnt_clr = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    p_gap_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(az_en) || $fell(int_en) || $fell(ref_en)) |-> !(az_en || int_en || ref_en));
    p_order_az_int_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(az_en) |=> int_en);
    p_order_int_ref_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(int_en) |=> ref_en);
    p_order_ref_az_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_en) |=> az_en);
    p_int_end_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(int_en) |-> $past(cnt_ovf));
    p_refsel_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_en && $past(ref_en)) |-> $stable(ref_neg));
endmodule

// File: rtl/dsadc_result_latch.sv
module dsadc_result_latch #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic [4*DIGITS-1:0] cnt_value,
    input  logic                sign_in,
    input  logic                over_in,
    output logic [4*DIGITS-1:0] res_bcd,
    output logic                res_neg,
    output logic                res_over,
    output logic                res_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_bcd   <= '0;
            res_neg   <= 1'b0;
            res_over  <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= stb;
            if (stb) begin
                res_bcd  <= cnt_value;
                res_neg  <= sign_in;
                res_over <= over_in;
            end
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_bcd) && $stable(res_over) && $stable(res_neg)));
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_zero,
    input  logic                pol_neg,
    output logic                az_en,
    output logic                int_en,
    output logic                ref_en,
    output logic                ref_neg,
    output logic [4*DIGITS-1:0] res_bcd,
    output logic                res_neg,
    output logic                res_over,
    output logic                res_valid
);
    localparam int CNT_W = BCD_W * DIGITS;

    logic             cnt_clr, cnt_en, cnt_ovf;
    logic [CNT_W-1:0] cnt_value;
    logic             latch_stb, latch_over, sign_q;

    bcd_chain #(.DIGITS(DIGITS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .value (cnt_value),
        .ovf   (cnt_ovf)
    );

    dsadc_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cnt_ovf    (cnt_ovf),
        .cmp_zero   (cmp_zero),
        .pol_neg    (pol_neg),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .latch_stb  (latch_stb),
        .latch_over (latch_over),
        .sign_q     (sign_q),
        .az_en      (az_en),
        .int_en     (int_en),
        .ref_en     (ref_en),
        .ref_neg    (ref_neg)
    );

    dsadc_result_latch #(.DIGITS(DIGITS)) u_lat (
        .clk       (clk),
        .rst       (rst),
        .stb       (latch_stb),
        .cnt_value (cnt_value),
        .sign_in   (sign_q),
        .over_in   (latch_over),
        .res_bcd   (res_bcd),
        .res_neg   (res_neg),
        .res_over  (res_over),
        .res_valid (res_valid)
    );

    p_over_nines_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_over) |-> (res_bcd == {DIGITS{4'h9}}));
    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_neg == $past(sign_q)));
    p_valid_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(ref_en) && !ref_en));
endmodule

// File: tb/dsadc_sequencer_test.sv
module dsadc_sequencer_test;
    localparam int DIGITS = 2;
    localparam int N      = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_zero = 1'b1;
    logic pol_neg = 1'b0;
    logic az_en, int_en, ref_en, ref_neg;
    logic [4*DIGITS-1:0] res_bcd;
    logic res_neg, res_over, res_valid;

    always #5 clk = ~clk;

    dsadc_sequencer #(.DIGITS(DIGITS)) uut (
        .clk(clk), .rst(rst), .cmp_zero(cmp_zero), .pol_neg(pol_neg),
        .az_en(az_en), .int_en(int_en), .ref_en(ref_en), .ref_neg(ref_neg),
        .res_bcd(res_bcd), .res_neg(res_neg), .res_over(res_over), .res_valid(res_valid)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [4*DIGITS-1:0] bcd;
        logic                neg;
        logic                over;
    } exp_t;
    exp_t sbq[$];

    int cur_k   = 0;
    bit cur_pol = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
        logic [4*DIGITS-1:0] r;
        int t;
        t = v;
        r = '0;
        for (int d = 0; d < DIGITS; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Driver: sets the stimulus for one conversion and queues its expected result.
    task automatic run_meas(input int k, input bit pol);
        exp_t e;
        cur_k   = k;
        cur_pol = pol;
        pol_neg = pol;
        e.bcd  = (k < N) ? to_bcd(k) : to_bcd(N - 1);
        e.neg  = pol;
        e.over = (k >= N);
        sbq.push_back(e);
        do @(negedge clk); while (!res_valid);
    endtask

    // Comparator model: crossing on read clock index cur_k; held high outside read (R10-style noise for R2).
    int rc = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (ref_en) begin
                cmp_zero = (rc == cur_k);
                rc++;
            end else begin
                cmp_zero = 1'b1;
                rc = 0;
            end
        end
    end

    // Monitor: scoreboard pops plus phase-sequence checks.
    logic [2:0] prev_en = 3'b000;
    int az_run = 0, int_run = 0, ref_run = 0, gap_run = 0;
    int last_phase = 2;
    int rk = 0;
    bit rpol = 1'b0;
    bit prev_valid = 1'b0;

    always @(negedge clk) begin
        logic [2:0] en;
        exp_t e;
        int p;
        if (!rst) begin
            en = {ref_en, int_en, az_en};
            if ($countones(en) > 1) chk(1'b0, "R4 onehot", 32'(en), 32'd1);
            if (res_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R6 unexpected result", 32'(res_bcd), 32'd0);
                end else begin
                    e = sbq.pop_front();
                    chk(res_bcd == e.bcd, e.over ? "R7 count" : "R3 count", 32'(res_bcd), 32'(e.bcd));
                    chk(res_over == e.over, "R7 overrange flag", 32'(res_over), 32'(e.over));
                    chk(res_neg == e.neg, "R8 sign", 32'(res_neg), 32'(e.neg));
                end
                chk(!prev_valid, "R6 pulse width", 32'(prev_valid), 32'd0);
            end
            prev_valid = res_valid;
            if ((en & ~prev_en) != 3'b000) begin
                p = en[0] ? 0 : (en[1] ? 1 : 2);
                if (gap_run > 0) begin
                    chk(gap_run == 1, "R4 gap length", 32'(gap_run), 32'd1);
                    chk(p == (last_phase + 1) % 3, "R1 phase order", 32'(p), 32'((last_phase + 1) % 3));
                end
                last_phase = p;
                if (p == 2) begin
                    rk = cur_k;
                    rpol = cur_pol;
                    chk(ref_neg == !rpol, "R5 reference sign", 32'(ref_neg), 32'(!rpol));
                end
            end
            if (prev_en[0] && !en[0]) chk(az_run == N, "R2 autozero length", 32'(az_run), 32'(N));
            if (prev_en[1] && !en[1]) chk(int_run == N, "R2 integrate length", 32'(int_run), 32'(N));
            if (prev_en[2] && !en[2])
                chk(ref_run == ((rk < N) ? rk + 1 : N), "R3 read length", 32'(ref_run), 32'((rk < N) ? rk + 1 : N));
            if (en[2] && ref_neg != !rpol) chk(1'b0, "R5 reference sign held", 32'(ref_neg), 32'(!rpol));
            az_run  = en[0] ? az_run + 1 : 0;
            int_run = en[1] ? int_run + 1 : 0;
            ref_run = en[2] ? ref_run + 1 : 0;
            gap_run = (en == 3'b000) ? gap_run + 1 : 0;
            prev_en = en;
        end
    end

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(az_en == 1'b1, "R9 az_en in reset", 32'(az_en), 32'd1);
        chk({int_en, ref_en, ref_neg} == 3'b000, "R9 other enables in reset", 32'({int_en, ref_en, ref_neg}), 32'd0);
        chk(res_bcd == '0, "R9 result in reset", 32'(res_bcd), 32'd0);
        chk({res_valid, res_over, res_neg} == 3'b000, "R9 flags in reset", 32'({res_valid, res_over, res_neg}), 32'd0);
        pol_neg = 1'b0;
        rst = 1'b0;
        run_meas(0, 1'b0);      // R3 crossing on first read clock
        run_meas(37, 1'b1);     // R3/R5/R8 negative input
        run_meas(N - 1, 1'b0);  // R7 boundary: last clock crossing is not overrange
        run_meas(N, 1'b1);      // R7 overrange
        run_meas(5, 1'b1);      // R1 recovery after overrange
        run_meas(500, 1'b0);    // R7 overrange, positive
        run_meas(12, 1'b0);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R6 all results delivered", 32'(sbq.size()), 32'd0);
        summary();
        $finish;
    end
endmodule